// File: doc/BRIEF.md
# Video Controller Host Register Port with VRAM Copy Engines

This block is the byte-wide host side of a video controller. A host CPU writes a 5-bit register index at offset 0, then reaches the selected 16-bit register as a low byte at offset 2 and a high byte at offset 3. Through this port the host fills video memory with an auto-advancing write pointer and reads it back through a prefetching, auto-advancing read pointer. The same path programs two copy engines. Reading offset 0 returns the status flags.

The first engine copies a block of words within video memory. It is armed by the length register and starts on the next line-start strobe from the display timing. The second engine fills the 256-word sprite attribute store from video memory when the vertical-blank strobe arrives. A word counter, an interrupt flag per engine and one interrupt output complete the block. Display timing and pixel generation are outside the block: they supply the strobes and read the attribute store.

Top module: `vdc_regport`

## Requirements
- R1: After reset the status byte reads 0x00, irq is low and no copy engine runs.
- R2: Offset 0 write loads the 5-bit register index. With index 0x02 selected, a write to offset 2 holds the low byte and a write to offset 3 stores the word at the write pointer (index 0x00). The pointer then advances by 1, 32, 64 or 128 for codes 0..3 of the control register (index 0x05) bits 12:11.
- R3: Loading the read pointer (index 0x01) prefetches the word there. Offsets 2 and 3 read its low and high bytes. Reading offset 3 with index 0x02 selected advances the read pointer by the same step and prefetches again.
- R4: Addresses at or above VRAM_WORDS read as 0, and writes to them leave memory unchanged.
- R5: Reading offset 0 returns bit 0 (block copy done), bit 1 (table copy done) and bit 6 (busy). It clears bits 0 and 1 and drops irq.
- R6: Writing the length high byte (index 0x12) arms a block copy. The copy starts only after the next line_start and moves length+1 words from the source (0x10) to the destination (0x11). Bit 2 of the DMA control register (0x0F) makes the source step down, and bit 3 makes the destination step down.
- R7: A finished block copy sets status bit 0 and irq only when DMA control bit 1 is set.
- R8: On vblank_start the 256-word attribute store is loaded from the table base (index 0x13), but only if that base was written since the last load or DMA control bit 4 is set. In each group of four words, words 0 and 1 are masked to 10 bits and word 2 to 11 bits.
- R9: With DMA control bit 0 set, status bit 1 and irq rise on the fourth line_start after the table load ends, and not before.
- R10: Status bit 6 is high while either engine owns the memory port. A host word store takes the port that cycle and the engine waits.
- R11: irq is high exactly while status bit 0 or bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | One-cycle host access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Byte offset: 0 index/status, 2 data low, 3 data high |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for the current offset |
| line_start | input | 1 | One-cycle strobe at each line start |
| vblank_start | input | 1 | One-cycle strobe at vertical blank start |
| sat_rd_addr | input | 8 | Attribute store read address |
| sat_rd_data | output | 16 | Attribute store read word |
| irq | output | 1 | Interrupt request |

## Verification
host_rdata is combinational from registers. Read side effects and host stores take effect at the clock edge of the access. The bench therefore samples each read during the access cycle and judges each effect on a later access. The block copy takes one cycle to register the start after line_start, then one cycle per word. The table load takes 256 cycles. The bench allows generous settling windows after these before it checks memory, the store or status. The fourth-line interrupt is sampled after each line strobe, so that an early or late flag is caught on the exact line.

// File: rtl/vdc_pkg.sv
package vdc_pkg;
  localparam logic [4:0] IDX_WADDR  = 5'h00;
  localparam logic [4:0] IDX_RADDR  = 5'h01;
  localparam logic [4:0] IDX_DATA   = 5'h02;
  localparam logic [4:0] IDX_CTRL   = 5'h05;
  localparam logic [4:0] IDX_DMACTL = 5'h0F;
  localparam logic [4:0] IDX_SRC    = 5'h10;
  localparam logic [4:0] IDX_DST    = 5'h11;
  localparam logic [4:0] IDX_LEN    = 5'h12;
  localparam logic [4:0] IDX_TBASE  = 5'h13;

  localparam logic [1:0] OFS_SEL = 2'd0;
  localparam logic [1:0] OFS_LO  = 2'd2;
  localparam logic [1:0] OFS_HI  = 2'd3;

  typedef enum logic [1:0] {ENG_IDLE, ENG_BLOCK, ENG_TABLE} eng_state_e;

  function automatic logic [15:0] step_of(input logic [1:0] code);
    case (code)
      2'd0:    return 16'd1;
      2'd1:    return 16'd32;
      2'd2:    return 16'd64;
      default: return 16'd128;
    endcase
  endfunction

  function automatic logic [15:0] put_byte(input logic [15:0] old, input logic hi,
                                           input logic [7:0] b);
    return hi ? {b, old[7:0]} : {old[15:8], b};
  endfunction
endpackage

// File: rtl/vdc_vram.sv
module vdc_vram #(
  parameter int WORDS = 256
) (
  input  logic        clk,
  input  logic        we,
  input  logic [15:0] waddr,
  input  logic [15:0] wdata,
  input  logic [15:0] raddr_a,
  output logic [15:0] rdata_a,
  input  logic [15:0] raddr_b,
  output logic [15:0] rdata_b
);
  localparam int IW = $clog2(WORDS);
  localparam logic [16:0] LIMIT = 17'(WORDS);

  logic [15:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we && ({1'b0, waddr} < LIMIT)) mem[waddr[IW-1:0]] <= wdata;
  end

  assign rdata_a = ({1'b0, raddr_a} < LIMIT) ? mem[raddr_a[IW-1:0]] : 16'h0000;
  assign rdata_b = ({1'b0, raddr_b} < LIMIT) ? mem[raddr_b[IW-1:0]] : 16'h0000;
endmodule

// File: rtl/vdc_sat.sv
module vdc_sat #(
  parameter int ENTRIES = 64,
  localparam int WORDS = 4 * ENTRIES,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [15:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [15:0]   rdata
);
  logic [15:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/vdc_dma.sv
module vdc_dma
  import vdc_pkg::*;
#(
  parameter int SAT_ENTRIES = 64,
  parameter int TDONE_LINES = 4,
  localparam int SAT_WORDS = 4 * SAT_ENTRIES,
  localparam int SAW = $clog2(SAT_WORDS),
  localparam int CW = $clog2(TDONE_LINES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           line_start,
  input  logic           vblank_start,
  input  logic           arm_block,
  input  logic           base_wr,
  input  logic [4:0]     dcr,
  input  logic [15:0]    src,
  input  logic [15:0]    dst,
  input  logic [15:0]    len,
  input  logic [15:0]    tbase,
  input  logic           stall,
  output logic [15:0]    mem_raddr,
  input  logic [15:0]    mem_rdata,
  output logic           mem_we,
  output logic [15:0]    mem_waddr,
  output logic [15:0]    mem_wdata,
  output logic           sat_we,
  output logic [SAW-1:0] sat_waddr,
  output logic [15:0]    sat_wdata,
  output logic           busy,
  output logic           block_done,
  output logic           table_done
);
  localparam logic [SAW-1:0] LAST = SAW'(SAT_WORDS - 1);
  localparam logic [CW-1:0]  CNT_LOAD = CW'(TDONE_LINES);

  eng_state_e     state, state_n;
  logic           armed, armed_n, go, go_n, tpend, tpend_n, dirty, dirty_n;
  logic [15:0]    cur_src, cur_src_n, cur_dst, cur_dst_n, cur_len, cur_len_n;
  logic [SAW-1:0] tidx, tidx_n;
  logic [CW-1:0]  cnt, cnt_n;

  always_comb begin
    state_n   = state;
    armed_n   = armed | arm_block;
    go_n      = go;
    tpend_n   = tpend;
    dirty_n   = dirty | base_wr;
    cur_src_n = cur_src;
    cur_dst_n = cur_dst;
    cur_len_n = cur_len;
    tidx_n    = tidx;
    cnt_n     = cnt;
    if (line_start && cnt != '0) cnt_n = cnt - 1'b1;
    case (state)
      ENG_IDLE: begin
        if (tpend) begin
          state_n   = ENG_TABLE;
          tpend_n   = 1'b0;
          cur_src_n = tbase;
          tidx_n    = '0;
        end else if (go) begin
          state_n   = ENG_BLOCK;
          go_n      = 1'b0;
          cur_src_n = src;
          cur_dst_n = dst;
          cur_len_n = len;
        end
      end
      ENG_BLOCK: begin
        if (!stall) begin
          cur_src_n = dcr[2] ? cur_src - 16'd1 : cur_src + 16'd1;
          cur_dst_n = dcr[3] ? cur_dst - 16'd1 : cur_dst + 16'd1;
          cur_len_n = cur_len - 16'd1;
          if (cur_len == 16'd0) state_n = ENG_IDLE;
        end
      end
      default: begin
        if (!stall) begin
          cur_src_n = cur_src + 16'd1;
          tidx_n    = tidx + 1'b1;
          if (tidx == LAST) begin
            state_n = ENG_IDLE;
            if (dcr[0]) cnt_n = CNT_LOAD;
          end
        end
      end
    endcase
    if (line_start && armed) begin
      go_n    = 1'b1;
      armed_n = arm_block;
    end
    if (vblank_start && (dirty || dcr[4])) begin
      tpend_n = 1'b1;
      dirty_n = base_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ENG_IDLE;
      armed   <= 1'b0;
      go      <= 1'b0;
      tpend   <= 1'b0;
      dirty   <= 1'b0;
      cur_src <= '0;
      cur_dst <= '0;
      cur_len <= '0;
      tidx    <= '0;
      cnt     <= '0;
    end else begin
      state   <= state_n;
      armed   <= armed_n;
      go      <= go_n;
      tpend   <= tpend_n;
      dirty   <= dirty_n;
      cur_src <= cur_src_n;
      cur_dst <= cur_dst_n;
      cur_len <= cur_len_n;
      tidx    <= tidx_n;
      cnt     <= cnt_n;
    end
  end

  assign mem_raddr = cur_src;
  assign mem_we    = (state == ENG_BLOCK) && !stall;
  assign mem_waddr = cur_dst;
  assign mem_wdata = mem_rdata;
  assign sat_we    = (state == ENG_TABLE) && !stall;
  assign sat_waddr = tidx;

  always_comb begin
    case (tidx[1:0])
      2'd0, 2'd1: sat_wdata = mem_rdata & 16'h03FF;
      2'd2:       sat_wdata = mem_rdata & 16'h07FF;
      default:    sat_wdata = mem_rdata;
    endcase
  end

  assign busy       = (state != ENG_IDLE);
  assign block_done = (state == ENG_BLOCK) && !stall && (cur_len == 16'd0) && dcr[1];
  assign table_done = line_start && (cnt == CW'(1));
endmodule

// File: rtl/vdc_regport.sv
module vdc_regport
  import vdc_pkg::*;
#(
  parameter int VRAM_WORDS  = 256,
  parameter int SAT_ENTRIES = 64,
  parameter int TDONE_LINES = 4,
  localparam int SAW = $clog2(4 * SAT_ENTRIES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_sel,
  input  logic           host_wr,
  input  logic [1:0]     host_addr,
  input  logic [7:0]     host_wdata,
  output logic [7:0]     host_rdata,
  input  logic           line_start,
  input  logic           vblank_start,
  input  logic [SAW-1:0] sat_rd_addr,
  output logic [15:0]    sat_rd_data,
  output logic           irq
);
  logic [4:0]  idx, idx_n;
  logic [15:0] waddr, waddr_n, raddr, raddr_n, rbuf, rbuf_n, wbuf, wbuf_n;
  logic [1:0]  inc_code, inc_code_n;
  logic [4:0]  dcr, dcr_n;
  logic [15:0] src, src_n, dst, dst_n, len, len_n, tbase, tbase_n;
  logic        flg_block, flg_block_n, flg_table, flg_table_n;

  logic        wr_data, wr_hi, wr_sel, rd_stat, rd_hi, host_commit, load_r;
  logic [15:0] step, host_rword;
  logic        dma_we, sat_we, busy, block_done, table_done, arm_block, base_wr;
  logic [15:0] dma_raddr, dma_rdata, dma_waddr, dma_wdata, sat_wdata;
  logic [SAW-1:0] sat_waddr;
  logic        vram_we;
  logic [15:0] vram_waddr, vram_wdata;

  assign wr_sel      = host_sel && host_wr && (host_addr == OFS_SEL);
  assign wr_data     = host_sel && host_wr && host_addr[1];
  assign wr_hi       = wr_data && host_addr[0];
  assign rd_stat     = host_sel && !host_wr && (host_addr == OFS_SEL);
  assign rd_hi       = host_sel && !host_wr && (host_addr == OFS_HI);
  assign step        = step_of(inc_code);
  assign host_commit = wr_hi && (idx == IDX_DATA);
  assign load_r      = (wr_data && idx == IDX_RADDR) || (rd_hi && idx == IDX_DATA);
  assign arm_block   = wr_hi && (idx == IDX_LEN);
  assign base_wr     = wr_data && (idx == IDX_TBASE);

  always_comb begin
    idx_n = idx; waddr_n = waddr; raddr_n = raddr; wbuf_n = wbuf;
    inc_code_n = inc_code; dcr_n = dcr; src_n = src; dst_n = dst;
    len_n = len; tbase_n = tbase;
    if (wr_sel) idx_n = host_wdata[4:0];
    if (wr_data) begin
      case (idx)
        IDX_WADDR:  waddr_n = put_byte(waddr, wr_hi, host_wdata);
        IDX_RADDR:  raddr_n = put_byte(raddr, wr_hi, host_wdata);
        IDX_DATA:   wbuf_n  = put_byte(wbuf, wr_hi, host_wdata);
        IDX_CTRL:   if (wr_hi) inc_code_n = host_wdata[4:3];
        IDX_DMACTL: if (!wr_hi) dcr_n = host_wdata[4:0];
        IDX_SRC:    src_n   = put_byte(src, wr_hi, host_wdata);
        IDX_DST:    dst_n   = put_byte(dst, wr_hi, host_wdata);
        IDX_LEN:    len_n   = put_byte(len, wr_hi, host_wdata);
        IDX_TBASE:  tbase_n = put_byte(tbase, wr_hi, host_wdata);
        default: ;
      endcase
    end
    if (host_commit) waddr_n = waddr + step;
    if (rd_hi && idx == IDX_DATA) raddr_n = raddr + step;
    rbuf_n      = load_r ? host_rword : rbuf;
    flg_block_n = (flg_block && !rd_stat) || block_done;
    flg_table_n = (flg_table && !rd_stat) || table_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0; waddr <= '0; raddr <= '0; rbuf <= '0; wbuf <= '0;
      inc_code <= '0; dcr <= '0; src <= '0; dst <= '0; len <= '0; tbase <= '0;
      flg_block <= 1'b0; flg_table <= 1'b0;
    end else begin
      idx <= idx_n; waddr <= waddr_n; raddr <= raddr_n; rbuf <= rbuf_n; wbuf <= wbuf_n;
      inc_code <= inc_code_n; dcr <= dcr_n; src <= src_n; dst <= dst_n;
      len <= len_n; tbase <= tbase_n;
      flg_block <= flg_block_n; flg_table <= flg_table_n;
    end
  end

  assign vram_we    = host_commit || dma_we;
  assign vram_waddr = host_commit ? waddr : dma_waddr;
  assign vram_wdata = host_commit ? {host_wdata, wbuf[7:0]} : dma_wdata;

  vdc_vram #(.WORDS(VRAM_WORDS)) u_vram (
    .clk(clk), .we(vram_we), .waddr(vram_waddr), .wdata(vram_wdata),
    .raddr_a(dma_raddr), .rdata_a(dma_rdata),
    .raddr_b(raddr_n), .rdata_b(host_rword)
  );

  vdc_dma #(.SAT_ENTRIES(SAT_ENTRIES), .TDONE_LINES(TDONE_LINES)) u_dma (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .vblank_start(vblank_start),
    .arm_block(arm_block), .base_wr(base_wr), .dcr(dcr), .src(src), .dst(dst),
    .len(len), .tbase(tbase), .stall(host_commit),
    .mem_raddr(dma_raddr), .mem_rdata(dma_rdata), .mem_we(dma_we),
    .mem_waddr(dma_waddr), .mem_wdata(dma_wdata),
    .sat_we(sat_we), .sat_waddr(sat_waddr), .sat_wdata(sat_wdata),
    .busy(busy), .block_done(block_done), .table_done(table_done)
  );

  vdc_sat #(.ENTRIES(SAT_ENTRIES)) u_sat (
    .clk(clk), .we(sat_we), .waddr(sat_waddr), .wdata(sat_wdata),
    .raddr(sat_rd_addr), .rdata(sat_rd_data)
  );

  always_comb begin
    case (host_addr)
      OFS_SEL: host_rdata = {1'b0, busy, 4'b0000, flg_table, flg_block};
      OFS_LO:  host_rdata = rbuf[7:0];
      OFS_HI:  host_rdata = rbuf[15:8];
      default: host_rdata = 8'h00;
    endcase
  end

  assign irq = flg_block || flg_table;
endmodule

// File: rtl/vdc_regport_chk.sv
module vdc_regport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_sel,
  input logic       host_wr,
  input logic [1:0] host_addr,
  input logic       irq,
  input logic       busy,
  input logic       block_done,
  input logic       table_done,
  input logic       line_start,
  input logic       dma_we,
  input logic       host_commit,
  input logic       flg_block
);
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && !host_wr && host_addr == 2'd0 && !block_done && !table_done) |=> !irq); // R5

  AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_commit && dma_we)); // R10

  AST_DMA_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dma_we |-> busy); // R10

  AST_TABLE_DONE_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    table_done |-> line_start); // R9

  AST_BLOCK_FLAG_FROM_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_block) |-> $past(busy)); // R7

  AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(block_done || table_done)); // R11
endmodule

bind vdc_regport vdc_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
  .host_addr(host_addr), .irq(irq), .busy(busy), .block_done(block_done),
  .table_done(table_done), .line_start(line_start), .dma_we(dma_we),
  .host_commit(host_commit), .flg_block(flg_block)
);

// File: tb/vdc_regport_bench.sv
module vdc_regport_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_wr = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic        line_start = 1'b0, vblank_start = 1'b0;
  logic [7:0]  sat_rd_addr = 8'h00;
  logic [15:0] sat_rd_data;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vdc_regport u_vdc_regport (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .line_start(line_start), .vblank_start(vblank_start),
    .sat_rd_addr(sat_rd_addr), .sat_rd_data(sat_rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_sel = 1'b0;
  endtask

  task automatic set_reg(input logic [4:0] i, input logic [15:0] v);
    hwrite(2'd0, {3'b000, i});
    hwrite(2'd2, v[7:0]);
    hwrite(2'd3, v[15:8]);
  endtask

  task automatic vram_wr(input logic [15:0] a, input logic [15:0] v);
    set_reg(5'h00, a);
    set_reg(5'h02, v);
  endtask

  task automatic read_word(output logic [15:0] w);
    logic [7:0] lo, hi;
    hread(2'd2, lo);
    hread(2'd3, hi);
    w = {hi, lo};
  endtask

  task automatic start_read(input logic [15:0] a);
    set_reg(5'h01, a);
    hwrite(2'd0, 8'h02);
  endtask

  task automatic pulse_line();
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
  endtask

  task automatic pulse_vblank();
    @(negedge clk); vblank_start = 1'b1;
    @(negedge clk); vblank_start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sat_peek(input logic [7:0] a, output logic [15:0] w);
    @(negedge clk); sat_rd_addr = a; #1 w = sat_rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] s;
    hread(2'd0, s);
    check("R1 status after reset", {8'h00, s}, 16'h0000);
    check("R1 irq after reset", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_write_read();
    logic [15:0] w;
    vram_wr(16'h0010, 16'h1111);
    set_reg(5'h02, 16'h2222);
    start_read(16'h0010);
    read_word(w); check("R2 R3 word at 0x10", w, 16'h1111);
    read_word(w); check("R3 auto-advance to 0x11", w, 16'h2222);
  endtask

  task automatic t_increments();
    logic [15:0] w;
    set_reg(5'h05, 16'h0800);
    vram_wr(16'h0005, 16'hA5A5);
    set_reg(5'h02, 16'h5A5A);
    start_read(16'h0005);
    read_word(w); check("R2 step32 first", w, 16'hA5A5);
    read_word(w); check("R2 R3 step32 at 0x25", w, 16'h5A5A);
    set_reg(5'h05, 16'h1800);
    vram_wr(16'h0007, 16'hC0DE);
    set_reg(5'h02, 16'hD00D);
    start_read(16'h0007);
    read_word(w); check("R2 step128 first", w, 16'hC0DE);
    read_word(w); check("R2 step128 at 0x87", w, 16'hD00D);
    set_reg(5'h05, 16'h0000);
  endtask

  task automatic t_out_of_range();
    logic [15:0] w;
    vram_wr(16'h00FF, 16'hEEEE);
    set_reg(5'h02, 16'hFFFF);
    start_read(16'h00FF);
    read_word(w); check("R4 last in range", w, 16'hEEEE);
    read_word(w); check("R4 beyond range reads 0", w, 16'h0000);
    start_read(16'h1000);
    read_word(w); check("R4 far address reads 0", w, 16'h0000);
    start_read(16'h0000);
    read_word(w); check("R4 ignored write did not alias to 0", {15'd0, w == 16'hFFFF}, 16'h0000);
  endtask

  task automatic t_block_copy();
    logic [15:0] w;
    logic [7:0] s;
    vram_wr(16'h0040, 16'hDEAD);
    set_reg(5'h02, 16'hDEAD);
    set_reg(5'h02, 16'hBEEF);
    set_reg(5'h0F, 16'h0002);
    set_reg(5'h10, 16'h0010);
    set_reg(5'h11, 16'h0040);
    set_reg(5'h12, 16'h0001);
    idle(5);
    start_read(16'h0040);
    read_word(w); check("R6 no copy before line start", w, 16'hDEAD);
    pulse_line();
    idle(10);
    check("R7 R11 irq after block copy", {15'd0, irq}, 16'h0001);
    hread(2'd0, s);
    check("R5 R7 status shows block done", {8'h00, s}, 16'h0001);
    hread(2'd0, s);
    check("R5 status cleared by read", {8'h00, s}, 16'h0000);
    check("R5 R11 irq cleared by read", {15'd0, irq}, 16'h0000);
    start_read(16'h0040);
    read_word(w); check("R6 first copied word", w, 16'h1111);
    read_word(w); check("R6 second copied word", w, 16'h2222);
    read_word(w); check("R6 length+1 words only", w, 16'hBEEF);
  endtask

  task automatic t_busy_no_irq();
    logic [7:0] s;
    set_reg(5'h0F, 16'h0000);
    set_reg(5'h10, 16'h0000);
    set_reg(5'h11, 16'h0060);
    set_reg(5'h12, 16'h000F);
    pulse_line();
    idle(1);
    hread(2'd0, s);
    check("R10 busy during copy", {8'h00, s}, 16'h0040);
    idle(30);
    hread(2'd0, s);
    check("R10 R7 idle, no done flag when disabled", {8'h00, s}, 16'h0000);
    check("R7 irq stays low when disabled", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_decrement();
    logic [15:0] w;
    logic [7:0] s;
    vram_wr(16'h007F, 16'h7777);
    set_reg(5'h02, 16'h0000);
    set_reg(5'h02, 16'h0000);
    set_reg(5'h0F, 16'h000E);
    set_reg(5'h10, 16'h0011);
    set_reg(5'h11, 16'h0081);
    set_reg(5'h12, 16'h0001);
    pulse_line();
    idle(10);
    hread(2'd0, s);
    check("R6 R7 decrement copy done", {8'h00, s}, 16'h0001);
    start_read(16'h007F);
    read_word(w); check("R6 decrement stops at length", w, 16'h7777);
    read_word(w); check("R6 decrement word at 0x80", w, 16'h1111);
    read_word(w); check("R6 decrement word at 0x81", w, 16'h2222);
  endtask

  task automatic t_table();
    logic [15:0] w;
    logic [7:0] s;
    vram_wr(16'h0020, 16'hFFFF);
    set_reg(5'h02, 16'hFFFF);
    set_reg(5'h02, 16'hFFFF);
    set_reg(5'h02, 16'hFFFF);
    set_reg(5'h0F, 16'h0001);
    set_reg(5'h13, 16'h0020);
    pulse_vblank();
    idle(300);
    sat_peek(8'd0, w); check("R8 word0 masked to 10 bits", w, 16'h03FF);
    sat_peek(8'd1, w); check("R8 word1 masked to 10 bits", w, 16'h03FF);
    sat_peek(8'd2, w); check("R8 word2 masked to 11 bits", w, 16'h07FF);
    sat_peek(8'd3, w); check("R8 word3 unmasked", w, 16'hFFFF);
    hread(2'd0, s);
    check("R9 no flag before lines", {8'h00, s}, 16'h0000);
    for (int i = 1; i <= 3; i++) begin
      pulse_line();
      check("R9 no flag before fourth line", {15'd0, irq}, 16'h0000);
    end
    pulse_line();
    check("R9 R11 irq on fourth line", {15'd0, irq}, 16'h0001);
    hread(2'd0, s);
    check("R9 status table done", {8'h00, s}, 16'h0002);
  endtask

  task automatic t_table_repeat();
    logic [15:0] w;
    set_reg(5'h0F, 16'h0000);
    vram_wr(16'h0020, 16'h0001);
    pulse_vblank();
    idle(300);
    sat_peek(8'd0, w); check("R8 no reload without base write", w, 16'h03FF);
    set_reg(5'h0F, 16'h0010);
    pulse_vblank();
    idle(300);
    sat_peek(8'd0, w); check("R8 auto-repeat reload", w, 16'h0001);
    sat_peek(8'd2, w); check("R8 auto-repeat word2 mask", w, 16'h07FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_read();
    t_increments();
    t_out_of_range();
    t_block_copy();
    t_busy_no_irq();
    t_decrement();
    t_table();
    t_table_repeat();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule